// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits inside a synchronous DRAM device and works out which column each beat of a read or write burst touches. A start strobe captures a start column together with a burst length code and an ordering bit. From the next cycle on, the block presents one column per clock until the burst is done. The burst can run in sequential or interleaved order. Either way the column stays inside the aligned block that the burst length defines.

A full-page burst walks the whole row in sequential order. It wraps from the top column back to zero and runs until a terminate strobe stops it. A terminate strobe stands for either a burst stop or a precharge. A new start strobe may arrive on any cycle, even in the middle of a burst, and it restarts the burst from the new column. Data storage, bank selection and the CAS-latency delay of read data are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `burstActive` is low and `curCol` is 0.
- R2: In the cycle after a clock edge that samples `startStb` high, `curCol` equals the sampled `startCol` and `burstActive` is high.
- R3: With `interleave` low and `lenCode` 1, 2 or 3 (lengths 2, 4 and 8), beat k has its low log2(N) column bits equal to (start low bits + k) mod N. The upper bits stay equal to those of the start column.
- R4: With `interleave` high and `lenCode` 1, 2 or 3, beat k is the start column XOR k.
- R5: `lenCode` 0 gives a burst of one beat. The reserved codes 4, 5 and 6 also give one beat.
- R6: `lenCode` 7 selects full page. It always uses sequential order whatever `interleave` is, wraps from 511 to 0, and stays active past 512 beats until it is terminated.
- R7: A burst of N beats keeps `burstActive` high for exactly N cycles. After the last beat, `curCol` holds the last beat's column.
- R8: A `termStb` sampled during a burst clears `burstActive` in the next cycle, and `curCol` keeps the column it had when the terminate was sampled.
- R9: A `startStb` sampled during a burst restarts the burst from the new column. When `startStb` and `termStb` are sampled in the same cycle, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startStb | input | 1 | Captures a start column and begins a burst |
| startCol | input | 9 | Start column of the burst |
| lenCode | input | 3 | Burst length: 0=1, 1=2, 2=4, 3=8, 7=full page, 4..6 treated as 1 |
| interleave | input | 1 | 1 selects interleaved order, 0 selects sequential |
| termStb | input | 1 | Burst stop or precharge: ends the current burst |
| curCol | output | 9 | Column of the current beat |
| burstActive | output | 1 | High while a burst is in progress |

## Verification
Sequential and interleaved bursts are run from the same unaligned start columns. Their column sequences differ only where a carry crosses a low bit, so the pair shows that the two orderings are kept apart and that the upper bits never change. A full-page burst is started near the top column with the interleave bit set. This shows the forced sequential order, the wrap through zero, and that the burst does not end by itself. Terminate, restart mid-burst, a start and a terminate in the same cycle, and the reserved length codes each show how the end of a burst is decided.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam logic [2:0] LEN_ONE  = 3'd0;
  localparam logic [2:0] LEN_TWO  = 3'd1;
  localparam logic [2:0] LEN_FOUR = 3'd2;
  localparam logic [2:0] LEN_EIGHT = 3'd3;
  localparam logic [2:0] LEN_FULL = 3'd7;

  typedef struct packed {
    logic load;  // capture start column, clear beat offset
    logic step;  // advance to next beat
  } colStrobe_t;
endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStb,
  input  logic [2:0] lenCode,
  input  logic       termStb,
  input  logic       atEnd,
  output colStrobe_t stb,
  output logic       active
);
  logic fullQ;

  always_comb begin
    stb = '0;
    if (startStb) stb.load = 1'b1;
    else if (active && !termStb && (fullQ || !atEnd)) stb.step = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      fullQ  <= 1'b0;
    end else if (startStb) begin
      active <= 1'b1;
      fullQ  <= (lenCode == LEN_FULL);
    end else if (active && termStb) begin
      active <= 1'b0;
    end else if (active && !fullQ && atEnd) begin
      active <= 1'b0;
    end
  end

  // R2
  start_sets_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> active);
  // R8
  term_clears_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && termStb && !startStb) |=> !active);
  // R6
  full_page_persists_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && fullQ && !startStb && !termStb) |=> active);
  // R7
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !startStb) |=> !active);
endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       stb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] curCol,
  output logic             atEnd
);
  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic [COL_W-1:0] baseQ, offQ, maskQ, lenMask;
  logic             ilvQ;

  always_comb begin
    case (lenCode)
      LEN_TWO:   lenMask = COL_W'(1);
      LEN_FOUR:  lenMask = COL_W'(3);
      LEN_EIGHT: lenMask = COL_W'(7);
      LEN_FULL:  lenMask = ALL_ONES;
      default:   lenMask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      offQ  <= '0;
      maskQ <= '0;
      ilvQ  <= 1'b0;
    end else if (stb.load) begin
      baseQ <= startCol;
      offQ  <= '0;
      maskQ <= lenMask;
      ilvQ  <= interleave && (lenCode != LEN_FULL);
    end else if (stb.step) begin
      offQ  <= offQ + 1'b1;
    end
  end

  logic [COL_W-1:0] seqSum;
  assign seqSum = baseQ + offQ;
  assign curCol = ilvQ ? (baseQ ^ (offQ & maskQ))
                       : ((baseQ & ~maskQ) | (seqSum & maskQ));
  assign atEnd  = ((offQ & maskQ) == maskQ);

  // R2
  load_start_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (curCol == $past(startCol)));
  // R3
  upper_bits_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> ((curCol & ~maskQ) == $past(curCol & ~maskQ)));
  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.step) |=> $stable(curCol));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic             termStb,
  output logic [COL_W-1:0] curCol,
  output logic             burstActive
);
  colStrobe_t stb;
  logic       atEnd;

  burst_col_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .lenCode(lenCode),
    .termStb(termStb), .atEnd(atEnd), .stb(stb), .active(burstActive)
  );

  burst_col_dp #(.COL_W(COL_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .curCol(curCol), .atEnd(atEnd)
  );
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic       termStb = 1'b0;
  logic [8:0] curCol;
  logic       burstActive;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_gen dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .termStb(termStb),
    .curCol(curCol), .burstActive(burstActive)
  );

  function automatic int lenOf(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic logic [8:0] expCol(input logic [8:0] s, input logic [2:0] c,
                                       input logic ilv, input int k);
    int n = lenOf(c);
    int b = int'(s);
    if (ilv && c != 3'd7) return 9'(b ^ k);
    return 9'((b - (b % n)) + (((b % n) + k) % n));
  endfunction

  task automatic chk(input string req, input logic [8:0] col, input logic act);
    checks++;
    if (curCol !== col || burstActive !== act) begin
      fails++;
      $display("FAIL %s: col=%0d act=%0b expected col=%0d act=%0b",
               req, curCol, burstActive, col, act);
    end
  endtask

  task automatic kick(input logic [8:0] s, input logic [2:0] c, input logic ilv);
    startStb = 1'b1; startCol = s; lenCode = c; interleave = ilv;
    @(negedge clk);
    startStb = 1'b0;
  endtask

  task automatic runBurst(input string req, input logic [8:0] s,
                          input logic [2:0] c, input logic ilv);
    int n = lenOf(c);
    @(negedge clk);
    kick(s, c, ilv);
    chk("R2", s, 1'b1);
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      chk(req, expCol(s, c, ilv, k), 1'b1);
    end
    @(negedge clk);
    chk("R7", expCol(s, c, ilv, n - 1), 1'b0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 9'd0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", 9'd0, 1'b0);
  endtask

  task automatic testSequential();
    runBurst("R3", 9'd5, 3'd1, 1'b0);
    runBurst("R3", 9'd6, 3'd2, 1'b0);
    runBurst("R3", 9'd173, 3'd3, 1'b0);
    runBurst("R3", 9'd510, 3'd3, 1'b0);
  endtask

  task automatic testInterleave();
    runBurst("R4", 9'd5, 3'd1, 1'b1);
    runBurst("R4", 9'd6, 3'd2, 1'b1);
    runBurst("R4", 9'd173, 3'd3, 1'b1);
  endtask

  task automatic testShort();
    runBurst("R5", 9'd77, 3'd0, 1'b0);
    runBurst("R5", 9'd300, 3'd4, 1'b1);
    runBurst("R5", 9'd301, 3'd5, 1'b0);
    runBurst("R5", 9'd302, 3'd6, 1'b1);
  endtask

  task automatic testFullPage();
    @(negedge clk);
    kick(9'd508, 3'd7, 1'b1);
    chk("R6", 9'd508, 1'b1);
    for (int k = 1; k < 600; k++) begin
      @(negedge clk);
      chk("R6", 9'((508 + k) % 512), 1'b1);
    end
    termStb = 1'b1;
    @(negedge clk);
    termStb = 1'b0;
    chk("R8", 9'((508 + 599) % 512), 1'b0);
  endtask

  task automatic testTerminate();
    @(negedge clk);
    kick(9'd40, 3'd3, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R8", 9'd42, 1'b1);
    termStb = 1'b1;
    @(negedge clk);
    termStb = 1'b0;
    chk("R8", 9'd42, 1'b0);
    @(negedge clk);
    chk("R8", 9'd42, 1'b0);
  endtask

  task automatic testRestart();
    @(negedge clk);
    kick(9'd16, 3'd3, 1'b0);
    @(negedge clk);
    chk("R9", 9'd17, 1'b1);
    startStb = 1'b1; termStb = 1'b1; startCol = 9'd99; lenCode = 3'd2; interleave = 1'b1;
    @(negedge clk);
    startStb = 1'b0; termStb = 1'b0;
    chk("R9", 9'd99, 1'b1);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk("R9", 9'(99 ^ k), 1'b1);
    end
    @(negedge clk);
    chk("R9", 9'(99 ^ 3), 1'b0);
  endtask

  initial begin
    testReset();
    testSequential();
    testInterleave();
    testShort();
    testFullPage();
    testTerminate();
    testRestart();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule